// File: doc/BRIEF.md
# Binary Pixel Row Hit Logger

This block is the digital readout for one row of binary pixels. Each pixel gives a single bit: hit or no hit. While a bunch train is running, every bunch-crossing strobe samples the row. Hits from pixels flagged in a noise-mask register are removed. For each remaining hit, the block builds a record made of the crossing timestamp and the pixel index, and stores it in an on-chip memory.

The memory is drained in the quiet time between trains. A single-cycle read request returns the oldest unread record, and an empty flag shows when every record has been read. If the memory fills during a train, later records are dropped and a sticky overflow flag is raised. That flag clears when the next train starts.

Top module: `pixrow_hit_logger`

## Requirements
- R1: After reset, `rd_valid` and `overflow` are 0, `rd_empty` is 1, and the mask holds all zeros.
- R2: A pixel whose mask bit is 1 never produces a stored record. A stored index is always below `NUM_PIX`.
- R3: Each record is `{timestamp[TS_W-1:0], index[IDX_W-1:0]}`, 19 bits by default. The timestamp occupies the upper bits and the pixel index (0 to 35) the lower 6 bits.
- R4: When several unmasked pixels hit in one crossing, one record is written per clock cycle, in ascending pixel-index order. This finishes before the next strobe, provided strobes are at least `NUM_PIX`+1 cycles apart.
- R5: The timestamp is 0 for the first crossing of a train and rises by one with each strobe. It clears whenever `train_active` is low.
- R6: Once `DEPTH` records are stored, further records are discarded and `overflow` goes to 1. It stays at 1 until the cycle after the next rising edge of `train_active`.
- R7: A read request is served only while `train_active` is low. A request made during a train gives no `rd_valid` and does not consume a record.
- R8: Reads return records in write order, each with a one-cycle `rd_valid` in the cycle after the request. `rd_empty` is 1 exactly when no unread record remains, and a request while empty gives no `rd_valid`.
- R9: `mask_we` loads `mask_wdata` into the mask only while `train_active` is low. A write during a train leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| train_active | input | 1 | High during a bunch train (acquisition window) |
| bx_strobe | input | 1 | One-cycle pulse per bunch crossing |
| pix_hit | input | NUM_PIX | Binary hit bits of the row, sampled on the strobe |
| mask_we | input | 1 | Mask write enable |
| mask_wdata | input | NUM_PIX | New mask value; a 1 silences that pixel |
| rd_req | input | 1 | Read the next stored record |
| rd_valid | output | 1 | `rd_data` holds a record this cycle |
| rd_data | output | TS_W+IDX_W | Record {timestamp, pixel index} |
| rd_empty | output | 1 | No unread record remains |
| overflow | output | 1 | Sticky: records were dropped because the memory was full |

## Verification
Timing of each result, counted from the clock edge that registers a stimulus:
- The hit vector is captured at the edge that sees the strobe. The first record is written one edge later, and each following edge writes one more. The bench therefore waits 40 cycles after each strobe before driving the next one.
- Read data and `rd_valid` appear one edge after the request. The bench raises a request on a falling edge and samples on the next falling edge.
- `overflow` rises one edge after the first rejected write, and `rd_empty` follows the pointers immediately.
- Flags are checked a few cycles after the train ends, once all pending writes have settled.

Expected records come from a bench model. The model applies the mask, ascending order, timestamp counting and the depth limit to the stimulus.

// File: rtl/pixrow_pkg.sv
// Shared default sizes for the pixel-row hit logger.
// Assumes: modules take these as parameter defaults and may override them.
package pixrow_pkg;
    localparam int DEF_NUM_PIX = 36;
    localparam int DEF_TS_W    = 13;
    localparam int DEF_DEPTH   = 64;
endpackage

// File: rtl/pixrow_prio_enc.sv
// Lowest-index-first priority encoder over the pending hit vector.
// Assumes: IDX_W is wide enough to hold NUM_PIX-1.
module pixrow_prio_enc #(
    parameter int NUM_PIX = pixrow_pkg::DEF_NUM_PIX,
    parameter int IDX_W   = $clog2(NUM_PIX)
) (
    input  logic [NUM_PIX-1:0] vec,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);
    // Scan downwards so the lowest set bit is the last one assigned.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_PIX - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/pixrow_hit_capture.sv
// Holds the noise mask and the crossing timestamp. Latches the masked hit
// vector on each strobe and retires one pending bit per write cycle.
// Assumes: strobes are at least NUM_PIX+1 cycles apart (a new capture
// replaces any bits still pending).
module pixrow_hit_capture #(
    parameter int NUM_PIX = pixrow_pkg::DEF_NUM_PIX,
    parameter int TS_W    = pixrow_pkg::DEF_TS_W,
    parameter int IDX_W   = $clog2(NUM_PIX)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               train_active,
    input  logic               bx_strobe,
    input  logic [NUM_PIX-1:0] pix_hit,
    input  logic               mask_we,
    input  logic [NUM_PIX-1:0] mask_wdata,
    input  logic               retire,
    input  logic [IDX_W-1:0]   retire_idx,
    output logic [NUM_PIX-1:0] pend,
    output logic [TS_W-1:0]    pend_ts,
    output logic [NUM_PIX-1:0] mask_q
);
    logic [TS_W-1:0]    ts_q;
    logic [NUM_PIX-1:0] retire_bit;

    assign retire_bit = retire ? (NUM_PIX'(1) << retire_idx) : '0;

    // Mask register: loads only outside the train.
    always_ff @(posedge clk) begin
        if (!rst_n)                       mask_q <= '0;
        else if (mask_we && !train_active) mask_q <= mask_wdata;
    end

    // Crossing counter: held at zero while idle, +1 per strobe in a train.
    always_ff @(posedge clk) begin
        if (!rst_n || !train_active) ts_q <= '0;
        else if (bx_strobe)          ts_q <= ts_q + 1'b1;
    end

    // Pending vector: capture masked hits with their timestamp, else retire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= '0;
            pend_ts <= '0;
        end else if (bx_strobe && train_active) begin
            pend    <= pix_hit & ~mask_q;
            pend_ts <= ts_q;
        end else begin
            pend    <= pend & ~retire_bit;
        end
    end
endmodule

// File: rtl/pixrow_rec_mem.sv
// Record store with a write pointer, a read pointer, sticky overflow and a
// registered sequential read port.
// Assumes: clear pulses once at train start; rd_en is already gated to idle.
module pixrow_rec_mem #(
    parameter int REC_W = pixrow_pkg::DEF_TS_W + 6,
    parameter int DEPTH = pixrow_pkg::DEF_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             wr_en,
    input  logic [REC_W-1:0] wr_data,
    input  logic             rd_en,
    output logic             rd_valid,
    output logic [REC_W-1:0] rd_data,
    output logic             rd_empty,
    output logic             overflow
);
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [REC_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0] wr_cnt, rd_ptr;
    logic             full, do_rd;

    assign full     = (wr_cnt == CNT_W'(DEPTH));
    assign rd_empty = (rd_ptr == wr_cnt);
    assign do_rd    = rd_en && !rd_empty;

    // Storage array: written while space remains.
    always_ff @(posedge clk) begin
        if (wr_en && !full) mem[wr_cnt[AW-1:0]] <= wr_data;
    end

    // Write side: count stored records, flag dropped ones.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_cnt   <= '0;
            overflow <= 1'b0;
        end else if (wr_en) begin
            if (full) overflow <= 1'b1;
            else      wr_cnt   <= wr_cnt + 1'b1;
        end
    end

    // Read side: hand out the oldest unread record, one per request.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rd_ptr   <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= do_rd;
            if (do_rd) begin
                rd_data <= mem[rd_ptr[AW-1:0]];
                rd_ptr  <= rd_ptr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pixrow_hit_logger.sv
// Top of the row hit logger: capture, serialising encoder and record store.
// Assumes: bx_strobe only matters while train_active is high; reads are
// issued only between trains.
module pixrow_hit_logger #(
    parameter int NUM_PIX = pixrow_pkg::DEF_NUM_PIX,
    parameter int TS_W    = pixrow_pkg::DEF_TS_W,
    parameter int DEPTH   = pixrow_pkg::DEF_DEPTH,
    localparam int IDX_W  = $clog2(NUM_PIX),
    localparam int REC_W  = TS_W + IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               train_active,
    input  logic               bx_strobe,
    input  logic [NUM_PIX-1:0] pix_hit,
    input  logic               mask_we,
    input  logic [NUM_PIX-1:0] mask_wdata,
    input  logic               rd_req,
    output logic               rd_valid,
    output logic [REC_W-1:0]   rd_data,
    output logic               rd_empty,
    output logic               overflow
);
    logic               train_q, train_start;
    logic [NUM_PIX-1:0] pend, mask_q;
    logic [TS_W-1:0]    pend_ts;
    logic               wr_en;
    logic [IDX_W-1:0]   wr_idx;
    logic [REC_W-1:0]   wr_data;

    // Train edge detector: marks the first cycle of each train.
    always_ff @(posedge clk) begin
        if (!rst_n) train_q <= 1'b0;
        else        train_q <= train_active;
    end
    assign train_start = train_active && !train_q;

    pixrow_hit_capture #(.NUM_PIX(NUM_PIX), .TS_W(TS_W), .IDX_W(IDX_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .train_active(train_active),
        .bx_strobe(bx_strobe), .pix_hit(pix_hit),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .retire(wr_en), .retire_idx(wr_idx),
        .pend(pend), .pend_ts(pend_ts), .mask_q(mask_q)
    );

    pixrow_prio_enc #(.NUM_PIX(NUM_PIX), .IDX_W(IDX_W)) u_enc (
        .vec(pend), .found(wr_en), .idx(wr_idx)
    );

    assign wr_data = {pend_ts, wr_idx};

    pixrow_rec_mem #(.REC_W(REC_W), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .rst_n(rst_n), .clear(train_start),
        .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_req && !train_active),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_empty(rd_empty), .overflow(overflow)
    );
endmodule

// File: rtl/pixrow_hit_logger_chk.sv
// Property checker for the row hit logger, bound to the top module.
// Assumes: the mask is not rewritten while writes from a train are pending.
module pixrow_hit_logger_chk #(
    parameter int NUM_PIX = 36,
    parameter int TS_W    = 13,
    parameter int IDX_W   = 6
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    train_active,
    input logic                    mask_we,
    input logic                    rd_req,
    input logic                    rd_valid,
    input logic                    rd_empty,
    input logic                    overflow,
    input logic [NUM_PIX-1:0]      mask_q,
    input logic                    wr_en,
    input logic [TS_W+IDX_W-1:0]   wr_data
);
    logic [IDX_W-1:0] w_idx;
    logic [TS_W-1:0]  w_ts;
    logic             ta_q;
    assign w_idx = wr_data[IDX_W-1:0];
    assign w_ts  = wr_data[TS_W+IDX_W-1:IDX_W];

    // Independent copy of the train level for spotting train start.
    always_ff @(posedge clk) begin
        if (!rst_n) ta_q <= 1'b0;
        else        ta_q <= train_active;
    end

    p_mask_blocks_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (32'(w_idx) < NUM_PIX) && (((mask_q >> w_idx) & NUM_PIX'(1)) == '0));

    p_ascending_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en) && (w_ts == $past(w_ts))) |-> (w_idx > $past(w_idx)));

    p_overflow_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !(train_active && !ta_q)) |=> overflow);

    p_read_idle_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(rd_req) && !$past(train_active)));

    p_empty_no_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_empty) |=> !rd_valid);

    p_mask_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (train_active && mask_we) |=> $stable(mask_q));
endmodule

bind pixrow_hit_logger pixrow_hit_logger_chk #(
    .NUM_PIX(NUM_PIX), .TS_W(TS_W), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .train_active(train_active), .mask_we(mask_we),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_empty(rd_empty),
    .overflow(overflow), .mask_q(mask_q), .wr_en(wr_en), .wr_data(wr_data)
);

// File: tb/pixrow_hit_logger_bench.sv
// Self-checking bench: directed corner cases plus seeded random hit patterns.
module pixrow_hit_logger_bench;
    localparam int NP = 36, TSW = 13, DEP = 64, IW = 6, RW = TSW + IW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic train_active = 1'b0, bx_strobe = 1'b0, mask_we = 1'b0, rd_req = 1'b0;
    logic [NP-1:0] pix_hit = '0, mask_wdata = '0;
    logic rd_valid, rd_empty, overflow;
    logic [RW-1:0] rd_data;

    int n_run = 0, n_fail = 0;
    logic [RW-1:0] exp_q[$];
    logic [NP-1:0] m_mask = '0;
    int m_ts = 0;
    bit m_ovf = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pixrow_hit_logger #(.NUM_PIX(NP), .TS_W(TSW), .DEPTH(DEP)) u_pixrow_hit_logger (
        .clk(clk), .rst_n(rst_n), .train_active(train_active), .bx_strobe(bx_strobe),
        .pix_hit(pix_hit), .mask_we(mask_we), .mask_wdata(mask_wdata), .rd_req(rd_req),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_empty(rd_empty), .overflow(overflow)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [RW-1:0] mk_rec(input int ts, input int idx);
        return {TSW'(ts), IW'(idx)};
    endfunction

    // Model of one crossing: mask, ascending order, depth limit.
    function automatic void model_cross(input logic [NP-1:0] hits);
        for (int i = 0; i < NP; i++) begin
            if (hits[i] && !m_mask[i]) begin
                if (exp_q.size() < DEP) exp_q.push_back(mk_rec(m_ts, i));
                else                    m_ovf = 1'b1;
            end
        end
        m_ts++;
    endfunction

    task automatic write_mask(input logic [NP-1:0] m);
        @(negedge clk); mask_we = 1'b1; mask_wdata = m;
        @(negedge clk); mask_we = 1'b0;
        if (!train_active) m_mask = m;
    endtask

    task automatic start_train();
        @(negedge clk); train_active = 1'b1;
        m_ts = 0; m_ovf = 1'b0; exp_q.delete();
        repeat (2) @(negedge clk);
        chk(overflow == 1'b0, "R6", "overflow after train start", 64'(overflow), 0);
    endtask

    task automatic crossing(input logic [NP-1:0] hits);
        @(negedge clk); pix_hit = hits; bx_strobe = 1'b1;
        @(negedge clk); bx_strobe = 1'b0; pix_hit = '0;
        model_cross(hits);
        repeat (40) @(negedge clk);
    endtask

    task automatic read_one(output logic v, output logic [RW-1:0] d);
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        v = rd_valid; d = rd_data;
    endtask

    task automatic drain();
        logic v;
        logic [RW-1:0] d;
        @(negedge clk); train_active = 1'b0;
        repeat (3) @(negedge clk);
        chk(overflow == m_ovf, "R6", "overflow after train", 64'(overflow), 64'(m_ovf));
        chk(rd_empty == (exp_q.size() == 0), "R8", "empty before read",
            64'(rd_empty), 64'(exp_q.size() == 0));
        while (exp_q.size() > 0) begin
            logic [RW-1:0] e;
            e = exp_q.pop_front();
            read_one(v, d);
            chk(v == 1'b1, "R8", "rd_valid", 64'(v), 1);
            chk(d == e, "R3/R4/R5", "record", 64'(d), 64'(e));
        end
        chk(rd_empty == 1'b1, "R8", "empty after drain", 64'(rd_empty), 1);
        read_one(v, d);
        chk(v == 1'b0, "R8", "read when empty", 64'(v), 0);
    endtask

    function automatic logic [NP-1:0] rnd_hits();
        logic [63:0] a, b, c;
        a = {$urandom, $urandom}; b = {$urandom, $urandom}; c = {$urandom, $urandom};
        return NP'(a & b & c);
    endfunction

    initial begin
        logic v;
        logic [RW-1:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_valid == 1'b0, "R1", "rd_valid at reset", 64'(rd_valid), 0);
        chk(rd_empty == 1'b1, "R1", "rd_empty at reset", 64'(rd_empty), 1);
        chk(overflow == 1'b0, "R1", "overflow at reset", 64'(overflow), 0);

        // R1: reset mask is clear, so all 36 pixels record in ascending order.
        start_train();
        crossing({NP{1'b1}});
        drain();

        // R2/R4/R5: masked pixels, edge indices, empty and fully masked crossings.
        write_mask(NP'((64'd1 << 3) | (64'd1 << 17) | (64'd1 << 20)));
        start_train();
        crossing({NP{1'b1}});
        crossing(NP'((64'd1 << 35) | 64'd1));
        crossing('0);
        crossing(NP'((64'd1 << 3) | (64'd1 << 17)));
        crossing(NP'(64'd1 << 20));
        drain();

        // R6: three full crossings overfill the memory.
        write_mask('0);
        start_train();
        for (int k = 0; k < 3; k++) crossing({NP{1'b1}});
        drain();

        // R6/R7/R9: flag cleared, read during train ignored, mask write ignored.
        write_mask(NP'(64'd1 << 5));
        start_train();
        crossing(NP'((64'd1 << 5) | (64'd1 << 6)));
        read_one(v, d);
        chk(v == 1'b0, "R7", "read during train", 64'(v), 0);
        write_mask({NP{1'b1}});
        crossing(NP'((64'd1 << 5) | (64'd1 << 9) | (64'd1 << 34)));
        drain();

        // Random crossings under a random mask.
        write_mask(rnd_hits());
        for (int t = 0; t < 3; t++) begin
            start_train();
            for (int k = 0; k < 10; k++) crossing(rnd_hits());
            drain();
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule